// File: doc/BRIEF.md
# Vertical-Blank-Synchronised Frame Capture Controller

This block sequences the capture of one interlaced video frame into a frame store. Software sets a capture request bit. The controller waits for the next vertical blanking interval. It then enables frame-store writes for the even field, pauses through the blank that separates the fields, and enables writes again for the odd field. Writes stop at the start of the blank that follows the odd field. While writes are enabled, the controller supplies the frame-store line address. Even rows are used in the first field and odd rows in the second.

The block also registers the display-source bit. This bit picks either the live camera input or the stored frame for the display path. The block also builds a status byte that software polls. The byte carries a blanking flag, a busy flag and an odd-field flag. Its top bits are tied low, so a fitted controller can never read back as all ones, which is the value that signals an empty slot.

There is no data stream at this block's boundary. Every input and output is a plain level or a one-cycle strobe. All inputs are synchronous to `clk`.

Top module: `frame_acq_ctrl`

## Requirements
- R1: Reset gives a status byte of 0x00, write enable low and the display select low. The status byte is laid out as follows. Bit 0 is the blanking input as sampled at the last clock edge. Bit 1 is busy. Bit 2 is high while the odd field is being written. Bits 7..3 are always 0, so the status byte never equals 0xFF.
- R2: A 0-to-1 change of `acq_i` while idle sets busy from the next clock edge. Busy stays high until the capture completes.
- R3: After a request, capture starts at the next rising edge of `vblank_i`. A request that arrives while the blank is already high waits for the following rise. A request in the same cycle as a rise uses that rise.
- R4: Write enable goes high in the cycle after the starting blank ends, for the even field. It goes low at the next blank rise. It goes high again after that blank ends, for the odd field. It drops, and busy clears, at the next blank rise.
- R5: At the start of the even field the line address is 0, and at the start of the odd field it is 1. Each `line_i` pulse inside a field advances the address by 2 from the next cycle.
- R6: Once the line count reaches `LINES` or more, write enable stays low for the rest of that field.
- R7: A request stays consumed after the capture completes. Holding `acq_i` high starts no further capture. Toggling `acq_i` during a capture has no effect. A new capture needs `acq_i` to be cleared and then set again.
- R8: `disp_stored_o` follows `stored_i` one cycle later. A value of 1 selects the frame store and 0 selects live video.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vblank_i | input | 1 | Vertical blanking level from the video timing |
| line_i | input | 1 | One-cycle strobe at each active line |
| acq_i | input | 1 | Capture request control bit |
| stored_i | input | 1 | Display source control bit (1 = stored) |
| cap_we_o | output | 1 | Frame-store write enable |
| cap_line_o | output | LINE_W | Frame-store line address |
| disp_stored_o | output | 1 | Display source select |
| status_o | output | 8 | Status byte |

## Verification
Two of the block's functions can fall in the same cycle. One is taking a capture request. The other is detecting the blank edge that starts the capture. The bench raises `acq_i` in exactly the cycle where `vblank_i` rises, and again one cycle after the rise. In the first case the even field must open at the end of that same blank. In the second case the request must wait a whole frame. A cycle model in the bench judges every cycle of the write enable, the line address and the status byte against these rules. It also checks that a line strobe coinciding with a field start loads the start row and does not advance it.

// File: rtl/frame_acq_pkg.sv
package frame_acq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ARMED  = 3'd1,
    PH_LEAD   = 3'd2,
    PH_EVEN   = 3'd3,
    PH_MID    = 3'd4,
    PH_ODD    = 3'd5
  } acq_phase_e;

  localparam int ST_VB_BIT   = 0;
  localparam int ST_BUSY_BIT = 1;
  localparam int ST_ODD_BIT  = 2;
  localparam int ST_WIDTH    = 8;

endpackage

// File: rtl/acq_edge_det.sv
module acq_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= sig_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_edge
    assign rise_o[g] = sig_i[g] & ~q[g];
    assign fall_o[g] = ~sig_i[g] & q[g];
  end

  assign q_o = q;
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import frame_acq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vb_rise,
  input  logic       vb_fall,
  input  logic       req_rise,
  input  logic       vblank_i,
  input  logic       vb_q,
  output logic       busy_o,
  output logic       in_field_o,
  output logic       odd_o,
  output logic       start_even_o,
  output logic       start_odd_o
);
  acq_phase_e ph, ph_nx;

  always_comb begin
    ph_nx = ph;
    unique case (ph)
      PH_IDLE:  if (req_rise) ph_nx = vb_rise ? PH_LEAD : PH_ARMED;
      PH_ARMED: if (vb_rise)  ph_nx = PH_LEAD;
      PH_LEAD:  if (vb_fall)  ph_nx = PH_EVEN;
      PH_EVEN:  if (vb_rise)  ph_nx = PH_MID;
      PH_MID:   if (vb_fall)  ph_nx = PH_ODD;
      PH_ODD:   if (vb_rise)  ph_nx = PH_IDLE;
      default:                ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= PH_IDLE;
    else        ph <= ph_nx;
  end

  assign busy_o       = (ph != PH_IDLE);
  assign in_field_o   = (ph == PH_EVEN) || (ph == PH_ODD);
  assign odd_o        = (ph == PH_ODD);
  assign start_even_o = (ph == PH_LEAD) && vb_fall;
  assign start_odd_o  = (ph == PH_MID) && vb_fall;

  // R2: leaving idle only happens on a fresh request
  a_r2_arm_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(req_rise));

  // R4: a field opens only when a blank has just ended
  a_r4_field_opens_at_blank_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_field_o) |-> ($past(vb_q) && !$past(vblank_i)));

  // R4: odd field closes only on a blank start
  a_r4_odd_closes_at_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(odd_o) |-> ($past(vblank_i) && !$past(vb_q)));
endmodule

// File: rtl/acq_line_gen.sv
module acq_line_gen #(
  parameter int LINES  = 480,
  parameter int LINE_W = $clog2(LINES),
  parameter int ROW_W  = $clog2(LINES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_even,
  input  logic              start_odd,
  input  logic              in_field,
  input  logic              odd,
  input  logic              line_i,
  output logic              row_ok_o,
  output logic [LINE_W-1:0] line_o
);
  localparam logic [ROW_W-1:0] ROW_LIM = ROW_W'(LINES);
  localparam logic [ROW_W-1:0] ROW_STEP = ROW_W'(2);

  logic [ROW_W-1:0] row;

  always_ff @(posedge clk) begin
    if (!rst_n)                               row <= '0;
    else if (start_even)                      row <= '0;
    else if (start_odd)                       row <= ROW_W'(1);
    else if (in_field && line_i && row_ok_o)  row <= row + ROW_STEP;
  end

  assign row_ok_o = (row < ROW_LIM);
  assign line_o   = row[LINE_W-1:0];

  // R5: row parity matches the field being written
  a_r5_row_parity: assert property (@(posedge clk) disable iff (!rst_n)
    in_field |-> (row[0] == odd));

  // R5: a line strobe in a field advances by two
  a_r5_step_two: assert property (@(posedge clk) disable iff (!rst_n)
    (in_field && line_i && row_ok_o && !start_even && !start_odd)
      |=> (row == $past(row) + ROW_STEP));
endmodule

// File: rtl/acq_status.sv
module acq_status
  import frame_acq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stored_i,
  input  logic                vb_q,
  input  logic                busy,
  input  logic                odd,
  output logic                disp_stored_o,
  output logic [ST_WIDTH-1:0] status_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) disp_stored_o <= 1'b0;
    else        disp_stored_o <= stored_i;
  end

  always_comb begin
    status_o              = '0;
    status_o[ST_VB_BIT]   = vb_q;
    status_o[ST_BUSY_BIT] = busy;
    status_o[ST_ODD_BIT]  = odd;
  end

  // R8: display select tracks the control bit one cycle later
  a_r8_disp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (disp_stored_o == $past(stored_i)));
endmodule

// File: rtl/frame_acq_ctrl.sv
module frame_acq_ctrl
  import frame_acq_pkg::*;
#(
  parameter int LINES  = 480,
  parameter int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vblank_i,
  input  logic              line_i,
  input  logic              acq_i,
  input  logic              stored_i,
  output logic              cap_we_o,
  output logic [LINE_W-1:0] cap_line_o,
  output logic              disp_stored_o,
  output logic [7:0]        status_o
);
  localparam int ROW_W = $clog2(LINES + 2);

  logic [1:0] e_q, e_rise, e_fall;
  logic busy, in_field, odd, st_even, st_odd, row_ok;

  acq_edge_det #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig_i({acq_i, vblank_i}),
    .q_o(e_q), .rise_o(e_rise), .fall_o(e_fall)
  );

  acq_sequencer u_seq (
    .clk(clk), .rst_n(rst_n),
    .vb_rise(e_rise[0]), .vb_fall(e_fall[0]), .req_rise(e_rise[1]),
    .vblank_i(vblank_i), .vb_q(e_q[0]),
    .busy_o(busy), .in_field_o(in_field), .odd_o(odd),
    .start_even_o(st_even), .start_odd_o(st_odd)
  );

  acq_line_gen #(.LINES(LINES), .LINE_W(LINE_W), .ROW_W(ROW_W)) u_line (
    .clk(clk), .rst_n(rst_n),
    .start_even(st_even), .start_odd(st_odd),
    .in_field(in_field), .odd(odd), .line_i(line_i),
    .row_ok_o(row_ok), .line_o(cap_line_o)
  );

  acq_status u_stat (
    .clk(clk), .rst_n(rst_n), .stored_i(stored_i),
    .vb_q(e_q[0]), .busy(busy), .odd(odd),
    .disp_stored_o(disp_stored_o), .status_o(status_o)
  );

  assign cap_we_o = in_field & row_ok;

  // R4: writes only happen inside a busy capture
  a_r4_we_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we_o |-> status_o[ST_BUSY_BIT]);

  // R7: a request seen while busy never restarts the sequence
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[ST_BUSY_BIT] && acq_i && !vblank_i) |=> status_o[ST_BUSY_BIT] || $past(vblank_i));

  // R1: the top status bits stay clear
  a_r1_top_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7:3] == 5'd0);
endmodule

// File: tb/test_frame_acq_ctrl.sv
module test_frame_acq_ctrl;
  localparam int LINES = 8;
  localparam int LW = $clog2(LINES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic vb = 1'b0, ln = 1'b0, acq = 1'b0, st = 1'b0;
  logic we;
  logic [LW-1:0] line;
  logic dsel;
  logic [7:0] status;

  int n_vec = 0, n_bad = 0;
  int m_ph = 0, m_row = 0;
  logic p_vb = 1'b0, p_acq = 1'b0;

  always #2 clk = ~clk;

  frame_acq_ctrl #(.LINES(LINES)) i_frame_acq_ctrl (
    .clk(clk), .rst_n(rst_n), .vblank_i(vb), .line_i(ln), .acq_i(acq),
    .stored_i(st), .cap_we_o(we), .cap_line_o(line),
    .disp_stored_o(dsel), .status_o(status)
  );

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(logic v, logic l);
    string stag;
    logic rv, fv, ra;
    int exp_stat;
    vb = v; ln = l;
    @(posedge clk); #1;
    rv = v && !p_vb; fv = !v && p_vb; ra = acq && !p_acq;
    stag = "R1";
    case (m_ph)
      0: if (ra) begin m_ph = rv ? 2 : 1; stag = rv ? "R3" : "R2"; end
      1: if (rv) m_ph = 2; else stag = "R3";
      2: if (fv) begin m_ph = 3; m_row = 0; end
      3: if (rv) m_ph = 4; else if (l && m_row < LINES) m_row += 2;
      4: if (fv) begin m_ph = 5; m_row = 1; end
      5: if (rv) m_ph = 0; else if (l && m_row < LINES) m_row += 2;
      default: m_ph = 0;
    endcase
    if (m_ph != 0 && ra && stag == "R1") stag = "R7";
    if (m_ph == 0 && acq && !ra) stag = "R7";
    p_vb = v; p_acq = acq;
    exp_stat = int'(v) | ((m_ph != 0) ? 2 : 0) | ((m_ph == 5) ? 4 : 0);
    chk(stag, int'(status), exp_stat);
    if ((m_ph == 3 || m_ph == 5) && m_row >= LINES) chk("R6", int'(we), 0);
    else chk("R4", int'(we), int'(m_ph == 3 || m_ph == 5));
    if (m_ph == 3 || m_ph == 5) chk("R5", int'(line), m_row % LINES);
    chk("R8", int'(dsel), int'(st));
  endtask

  task automatic blank(int n);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b0);
  endtask

  task automatic active(int n);
    for (int i = 0; i < n; i++) begin
      tick(1'b0, 1'b1); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    end
  endtask

  task automatic frame(int n);
    blank(3); active(n);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", int'(status), 0);
    chk("R1", int'(we), 0);
    chk("R1", int'(dsel), 0);
    rst_n = 1'b1;
    active(1);
    // sweep request offset and line count per field
    for (int d = 0; d < 4; d++) begin
      for (int n = 2; n <= 6; n += 2) begin
        for (int k = 0; k < d; k++) tick(1'b0, 1'b0);
        acq = 1'b1;
        st = d[0];
        active(1);
        frame(n); frame(n + d % 2);
        acq = 1'b0; st = ~st;
        frame(n); frame(1);
      end
    end
    // request coincident with the blank rise
    acq = 1'b0; active(1);
    acq = 1'b1; frame(4); frame(4); frame(2);
    acq = 1'b0; active(1);
    // request arriving mid-blank waits a full frame
    blank(1); acq = 1'b1; blank(2); active(3);
    frame(3); frame(3); frame(2);
    acq = 1'b0; active(1);
    // toggling during capture, then holding high afterwards
    acq = 1'b1; active(1); frame(2);
    acq = 1'b0; tick(1'b0, 1'b0); acq = 1'b1; active(2);
    frame(5); frame(3); frame(3);
    chk("R7", int'(status[1]), 0);
    frame(3);
    chk("R7", int'(we), 0);
    acq = 1'b0; active(1);
    // line strobe coinciding with field start, overflowing odd field
    acq = 1'b1; active(1);
    blank(3); tick(1'b0, 1'b1); active(5);
    blank(3); tick(1'b0, 1'b1); active(6);
    frame(1);
    acq = 1'b0; active(1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule